// File: doc/BRIEF.md
# Power-Up Soft-Start Sequencer

This block orders the digital side of a multi-rail power-up once the bias supply leaves its power-on reset. The analog soft-start ramp is stood in for by a cycle counter: a first ramp phase brings up the always-on standby rail, a fixed pause follows, and then a second ramp phase brings up every other enabled rail. At the end of each ramp the undervoltage monitors for the rails just raised are armed. At the end of the pause, one strobe captures the memory-voltage comparator bit and the two dual-rail configuration pins. Those values then hold until the next start-up.

When both sleep-request lines are high at that capture point, the block treats the start as an active-state wake. It then waits until the three main supply inputs have been good together for a settle window before the second ramp starts. The drive for the active-path switches of the dual rails turns on in that same cycle. If any main input drops during the wait, the window starts again. Asserting shutdown, or losing bias power-on reset, drops the block back to idle at any point, and a release starts a full new cycle.

Top module: `softstart_seq`

## Requirements
- R1: While `rst_n` is low, `porOk` is low or `shutdown` is high, every output is low by the next clock edge (all armed flags, latched values and the switch drive are cleared).
- R2: In the first cycle after `porOk` high with `shutdown` low is seen in idle, `rampStby` goes high. It stays high for exactly RAMP_LEN cycles.
- R3: `armStby` rises in the cycle after the standby ramp ends. Exactly PAUSE_LEN cycles later, `latchStrobe` is high for a single cycle.
- R4: On the edge that ends the `latchStrobe` cycle, `mem3v3` takes `memSelHigh` (1 selects the 3.3 V memory setting, 0 the 2.5 V setting), and `en3Lat` and `en5Lat` take `cfgEn3` and `cfgEn5`. Later changes on these inputs have no effect until the next start-up.
- R5: If `slpS3n` or `slpS5n` is low during the `latchStrobe` cycle (sleep start), `rampRest` goes high in the very next cycle and `swOn` stays low.
- R6: If both `slpS3n` and `slpS5n` are high during the `latchStrobe` cycle (active start), the second ramp waits until all three bits of `mainGood` have been high for SETTLE_LEN consecutive cycles. Any cycle with a low bit restarts that count.
- R7: On an active start, `swOn` rises in the same cycle that `rampRest` rises, and it stays high until shutdown or loss of reset.
- R8: `rampRest` stays high for exactly RAMP_LEN cycles. In the next cycle `armRest` and `ready` go high, and they hold.
- R9: Releasing shutdown, or restoring bias reset, after an abort runs the whole sequence again from the standby ramp, including a fresh capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| porOk | input | 1 | Bias supply is above its power-on reset level |
| shutdown | input | 1 | External shutdown request (soft-start node held low) |
| slpS3n | input | 1 | Suspend-to-RAM request line, low requests sleep |
| slpS5n | input | 1 | Soft-off request line, low requests sleep |
| mainGood | input | 3 | Good flags of the three main supply inputs |
| memSelHigh | input | 1 | Memory-select comparator result, 1 for the 3.3 V setting |
| cfgEn3 | input | 1 | Dual 3.3 V rail configuration pin |
| cfgEn5 | input | 1 | Dual 5 V rail configuration pin |
| rampStby | output | 1 | Standby rail ramp enable |
| rampRest | output | 1 | Ramp enable for the remaining rails |
| latchStrobe | output | 1 | One-cycle capture strobe for the selection inputs |
| armStby | output | 1 | Standby rail undervoltage monitor armed |
| armRest | output | 1 | Remaining rail undervoltage monitors armed |
| swOn | output | 1 | Active-path switch drive for the dual rails |
| ready | output | 1 | Sequence complete |
| mem3v3 | output | 1 | Latched memory setting, 1 for 3.3 V |
| en3Lat | output | 1 | Latched dual 3.3 V configuration |
| en5Lat | output | 1 | Latched dual 5 V configuration |

## Verification
The bench targets the ramp and pause lengths, where an off-by-one counter compare would stretch or shorten `rampStby` or delay the strobe by a cycle. It also targets a single-cycle drop of a main input in the middle of the settle wait, where a design that pauses the count instead of restarting it would start the second ramp too early. Other targets are selection inputs that change after the capture, which a transparent latch would pass through, and a sleep start, where a wrongly gated switch would drive the active path. Shutdown and reset loss are pulsed at random points in the sequence, and a free-running per-cycle model catches any state that survives an abort.

// File: rtl/softstart_pkg.sv
package softstart_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RAMP1 = 3'd1,
    ST_PAUSE = 3'd2,
    ST_LATCH = 3'd3,
    ST_WAIT  = 3'd4,
    ST_RAMP2 = 3'd5,
    ST_RUN   = 3'd6
  } seqState_t;

  typedef struct packed {
    logic clrAll;
    logic cntClr;
    logic cntInc;
    logic doLatch;
    logic armStbySet;
    logic armRestSet;
    logic swSet;
  } seqStrobe_t;

endpackage

// File: rtl/softstart_dp.sv
module softstart_dp
  import softstart_pkg::*;
#(
  parameter int RAMP_LEN   = 16,
  parameter int PAUSE_LEN  = 24,
  parameter int SETTLE_LEN = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  seqStrobe_t strb,
  input  logic       memSelHigh,
  input  logic       cfgEn3,
  input  logic       cfgEn5,
  input  logic       actReq,
  output logic       rampDone,
  output logic       pauseDone,
  output logic       settleDone,
  output logic       armStby,
  output logic       armRest,
  output logic       swOn,
  output logic       mem3v3,
  output logic       en3Lat,
  output logic       en5Lat,
  output logic       modeActive
);

  localparam int MAX_A   = (RAMP_LEN > PAUSE_LEN) ? RAMP_LEN : PAUSE_LEN;
  localparam int MAX_LEN = (MAX_A > SETTLE_LEN) ? MAX_A : SETTLE_LEN;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);
  localparam logic [CNT_W-1:0] RAMP_LAST   = CNT_W'(RAMP_LEN - 1);
  localparam logic [CNT_W-1:0] PAUSE_LAST  = CNT_W'(PAUSE_LEN - 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_LEN - 1);

  logic [CNT_W-1:0] cnt;

  // shared phase counter: one counter serves ramps, pause and settle window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (strb.clrAll || strb.cntClr) begin
      cnt <= '0;
    end else if (strb.cntInc) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign rampDone   = (cnt == RAMP_LAST);
  assign pauseDone  = (cnt == PAUSE_LAST);
  assign settleDone = (cnt == SETTLE_LAST);

  // sticky flags set by the control strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armStby <= 1'b0;
      armRest <= 1'b0;
      swOn    <= 1'b0;
    end else if (strb.clrAll) begin
      armStby <= 1'b0;
      armRest <= 1'b0;
      swOn    <= 1'b0;
    end else begin
      if (strb.armStbySet) armStby <= 1'b1;
      if (strb.armRestSet) armRest <= 1'b1;
      if (strb.swSet)      swOn    <= 1'b1;
    end
  end

  // one capture per start-up
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem3v3     <= 1'b0;
      en3Lat     <= 1'b0;
      en5Lat     <= 1'b0;
      modeActive <= 1'b0;
    end else if (strb.clrAll) begin
      mem3v3     <= 1'b0;
      en3Lat     <= 1'b0;
      en5Lat     <= 1'b0;
      modeActive <= 1'b0;
    end else if (strb.doLatch) begin
      mem3v3     <= memSelHigh;
      en3Lat     <= cfgEn3;
      en5Lat     <= cfgEn5;
      modeActive <= actReq;
    end
  end

  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CNT_W'(MAX_LEN));

  p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.doLatch && !strb.clrAll) |=> $stable(mem3v3) && $stable(en3Lat) && $stable(en5Lat));

endmodule

// File: rtl/softstart_ctrl.sv
module softstart_ctrl
  import softstart_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       porOk,
  input  logic       shutdown,
  input  logic       actReq,
  input  logic       allGood,
  input  logic       rampDone,
  input  logic       pauseDone,
  input  logic       settleDone,
  output seqStrobe_t strb,
  output logic       rampStby,
  output logic       rampRest,
  output logic       latchStrobe,
  output logic       ready
);

  seqState_t state, stateNxt;
  logic      abort;

  assign abort = !porOk || shutdown;

  always_comb begin
    stateNxt = state;
    strb     = '0;
    if (abort) begin
      stateNxt    = ST_IDLE;
      strb.clrAll = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          stateNxt    = ST_RAMP1;
          strb.cntClr = 1'b1;
        end
        ST_RAMP1: begin
          if (rampDone) begin
            stateNxt        = ST_PAUSE;
            strb.cntClr     = 1'b1;
            strb.armStbySet = 1'b1;
          end else begin
            strb.cntInc = 1'b1;
          end
        end
        ST_PAUSE: begin
          if (pauseDone) begin
            stateNxt    = ST_LATCH;
            strb.cntClr = 1'b1;
          end else begin
            strb.cntInc = 1'b1;
          end
        end
        ST_LATCH: begin
          strb.doLatch = 1'b1;
          strb.cntClr  = 1'b1;
          stateNxt     = actReq ? ST_WAIT : ST_RAMP2;
        end
        ST_WAIT: begin
          if (!allGood) begin
            strb.cntClr = 1'b1;
          end else if (settleDone) begin
            stateNxt    = ST_RAMP2;
            strb.cntClr = 1'b1;
            strb.swSet  = 1'b1;
          end else begin
            strb.cntInc = 1'b1;
          end
        end
        ST_RAMP2: begin
          if (rampDone) begin
            stateNxt        = ST_RUN;
            strb.cntClr     = 1'b1;
            strb.armRestSet = 1'b1;
          end else begin
            strb.cntInc = 1'b1;
          end
        end
        default: stateNxt = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNxt;
  end

  assign rampStby    = (state == ST_RAMP1);
  assign rampRest    = (state == ST_RAMP2);
  assign latchStrobe = (state == ST_LATCH);
  assign ready       = (state == ST_RUN);

  p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!porOk || shutdown) |=> (state == ST_IDLE));

  p_latch_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    latchStrobe |=> !latchStrobe);

endmodule

// File: rtl/softstart_seq.sv
module softstart_seq
  import softstart_pkg::*;
#(
  parameter int RAMP_LEN   = 16,
  parameter int PAUSE_LEN  = 24,
  parameter int SETTLE_LEN = 40,
  parameter int N_MAIN     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              porOk,
  input  logic              shutdown,
  input  logic              slpS3n,
  input  logic              slpS5n,
  input  logic [N_MAIN-1:0] mainGood,
  input  logic              memSelHigh,
  input  logic              cfgEn3,
  input  logic              cfgEn5,
  output logic              rampStby,
  output logic              rampRest,
  output logic              latchStrobe,
  output logic              armStby,
  output logic              armRest,
  output logic              swOn,
  output logic              ready,
  output logic              mem3v3,
  output logic              en3Lat,
  output logic              en5Lat
);

  seqStrobe_t strb;
  logic rampDone, pauseDone, settleDone, modeActive;
  logic actReq, allGood;

  assign actReq  = slpS3n && slpS5n;
  assign allGood = &mainGood;

  softstart_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .porOk      (porOk),
    .shutdown   (shutdown),
    .actReq     (actReq),
    .allGood    (allGood),
    .rampDone   (rampDone),
    .pauseDone  (pauseDone),
    .settleDone (settleDone),
    .strb       (strb),
    .rampStby   (rampStby),
    .rampRest   (rampRest),
    .latchStrobe(latchStrobe),
    .ready      (ready)
  );

  softstart_dp #(
    .RAMP_LEN  (RAMP_LEN),
    .PAUSE_LEN (PAUSE_LEN),
    .SETTLE_LEN(SETTLE_LEN)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .memSelHigh (memSelHigh),
    .cfgEn3     (cfgEn3),
    .cfgEn5     (cfgEn5),
    .actReq     (actReq),
    .rampDone   (rampDone),
    .pauseDone  (pauseDone),
    .settleDone (settleDone),
    .armStby    (armStby),
    .armRest    (armRest),
    .swOn       (swOn),
    .mem3v3     (mem3v3),
    .en3Lat     (en3Lat),
    .en5Lat     (en5Lat),
    .modeActive (modeActive)
  );

  p_arm_after_ramp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armStby) |-> $past(rampStby));

  p_sw_with_ramp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(swOn) |-> rampRest && modeActive);

  p_sw_needs_good_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(swOn) |-> $past(allGood));

  p_ready_armed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> armStby && armRest);

  p_sleep_no_sw_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (swOn && !modeActive) |-> 1'b0 == swOn);

endmodule

// File: tb/softstart_seq_bench.sv
module softstart_seq_bench;

  localparam int RAMP_LEN   = 16;
  localparam int PAUSE_LEN  = 24;
  localparam int SETTLE_LEN = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic porOk = 1'b0, shutdown = 1'b0, slpS3n = 1'b1, slpS5n = 1'b1;
  logic [2:0] mainGood = 3'b000;
  logic memSelHigh = 1'b0, cfgEn3 = 1'b0, cfgEn5 = 1'b0;
  logic rampStby, rampRest, latchStrobe, armStby, armRest, swOn, ready;
  logic mem3v3, en3Lat, en5Lat;

  int nCompared = 0;
  int nMismatch = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  softstart_seq #(
    .RAMP_LEN(RAMP_LEN), .PAUSE_LEN(PAUSE_LEN), .SETTLE_LEN(SETTLE_LEN), .N_MAIN(3)
  ) u_softstart_seq (
    .clk(clk), .rst_n(rst_n), .porOk(porOk), .shutdown(shutdown),
    .slpS3n(slpS3n), .slpS5n(slpS5n), .mainGood(mainGood),
    .memSelHigh(memSelHigh), .cfgEn3(cfgEn3), .cfgEn5(cfgEn5),
    .rampStby(rampStby), .rampRest(rampRest), .latchStrobe(latchStrobe),
    .armStby(armStby), .armRest(armRest), .swOn(swOn), .ready(ready),
    .mem3v3(mem3v3), .en3Lat(en3Lat), .en5Lat(en5Lat)
  );

  // reference model of the requirements: phase 0 idle, 1 standby ramp, 2 pause,
  // 3 capture, 4 settle wait, 5 rest ramp, 6 done
  int  mPh = 0;
  int  mCnt = 0;
  bit  mArmS, mArmR, mSw, mMem, mE3, mE5;

  always @(posedge clk) begin
    if (!rst_n || !porOk || shutdown) begin
      mPh = 0; mCnt = 0; mArmS = 0; mArmR = 0; mSw = 0; mMem = 0; mE3 = 0; mE5 = 0;
    end else begin
      case (mPh)
        0: begin mPh = 1; mCnt = 0; end
        1: if (mCnt == RAMP_LEN - 1) begin mPh = 2; mCnt = 0; mArmS = 1; end else mCnt++;
        2: if (mCnt == PAUSE_LEN - 1) begin mPh = 3; mCnt = 0; end else mCnt++;
        3: begin
          mMem = memSelHigh; mE3 = cfgEn3; mE5 = cfgEn5; mCnt = 0;
          mPh = (slpS3n && slpS5n) ? 4 : 5;
        end
        4: if (mainGood != 3'b111) mCnt = 0;
           else if (mCnt == SETTLE_LEN - 1) begin mPh = 5; mCnt = 0; mSw = 1; end
           else mCnt++;
        5: if (mCnt == RAMP_LEN - 1) begin mPh = 6; mCnt = 0; mArmR = 1; end else mCnt++;
        default: mPh = 6;
      endcase
    end
  end

  function automatic string bitTag(int idx);
    case (idx)
      9: return "R2";
      8: return "R8";
      7: return "R3";
      6: return "R3";
      5: return "R8";
      4: return "R7";
      3: return "R8";
      default: return "R4";
    endcase
  endfunction

  function automatic logic [9:0] expVec();
    return {mPh == 1, mPh == 5, mPh == 3, mArmS, mArmR, mSw, mPh == 6, mMem, mE3, mE5};
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    nCompared++;
    if (!ok) begin
      nMismatch++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // per-cycle comparison against the model, sampled on the falling edge
  always @(negedge clk) begin
    logic [9:0] act, exp;
    cycles++;
    if (rst_n && !finished) begin
      act = {rampStby, rampRest, latchStrobe, armStby, armRest, swOn, ready, mem3v3, en3Lat, en5Lat};
      exp = expVec();
      if (act !== exp) begin
        for (int i = 9; i >= 0; i--) begin
          if (act[i] !== exp[i]) begin
            check(1'b0, bitTag(i), act, exp);
            break;
          end
        end
      end else begin
        nCompared++;
      end
    end
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      check(1'b0, "watchdog", cycles, 150000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
      $finish;
    end
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int n;
    void'($urandom(32'd5150));
    tick(3);
    // R1: reset state
    check({rampStby, rampRest, latchStrobe, armStby, armRest, swOn, ready, mem3v3, en3Lat, en5Lat} == 10'd0,
          "R1", 0, 0);
    rst_n = 1'b1;
    tick(3);
    check(rampStby == 1'b0 && ready == 1'b0, "R1", rampStby, 0);

    // sleep start with 3.3 V memory selection
    slpS3n = 1'b0; slpS5n = 1'b1; memSelHigh = 1'b1; cfgEn3 = 1'b1; cfgEn5 = 1'b0;
    porOk = 1'b1;
    tick(1);
    check(rampStby == 1'b1, "R2", rampStby, 1);
    n = 0;
    while (rampStby) begin n++; tick(1); end
    check(n == RAMP_LEN, "R2", n, RAMP_LEN);
    check(armStby == 1'b1, "R3", armStby, 1);
    n = 0;
    while (!latchStrobe && n < 1000) begin n++; tick(1); end
    check(n == PAUSE_LEN, "R3", n, PAUSE_LEN);
    tick(1);
    check(latchStrobe == 1'b0, "R3", latchStrobe, 0);
    check(rampRest == 1'b1 && swOn == 1'b0, "R5", {rampRest, swOn}, 2);
    check(mem3v3 == 1'b1 && en3Lat == 1'b1 && en5Lat == 1'b0, "R4", {mem3v3, en3Lat, en5Lat}, 6);
    n = 0;
    while (rampRest) begin n++; tick(1); end
    check(n == RAMP_LEN, "R8", n, RAMP_LEN);
    check(ready == 1'b1 && armRest == 1'b1, "R8", {ready, armRest}, 3);
    memSelHigh = 1'b0; cfgEn3 = 1'b0; cfgEn5 = 1'b1;
    tick(5);
    check(mem3v3 == 1'b1 && en3Lat == 1'b1 && en5Lat == 1'b0, "R4", {mem3v3, en3Lat, en5Lat}, 6);
    check(swOn == 1'b0, "R5", swOn, 0);

    // shutdown then active restart with a main-input glitch during the wait
    shutdown = 1'b1;
    tick(1);
    check({armStby, armRest, ready, mem3v3, en3Lat} == 5'd0, "R1", {armStby, armRest, ready}, 0);
    slpS3n = 1'b1; slpS5n = 1'b1; mainGood = 3'b111; memSelHigh = 1'b0;
    shutdown = 1'b0;
    tick(1);
    check(rampStby == 1'b1, "R9", rampStby, 1);
    while (!latchStrobe) tick(1);
    tick(1);
    n = 0;
    while (!rampRest && n < 1000) begin
      n++;
      if (n == 10) mainGood = 3'b101;
      if (n == 11) mainGood = 3'b111;
      tick(1);
    end
    check(n > SETTLE_LEN, "R6", n, SETTLE_LEN + 10);
    check(swOn == 1'b1, "R7", swOn, 1);
    check(mem3v3 == 1'b0 && en5Lat == 1'b1, "R4", {mem3v3, en5Lat}, 1);
    while (!ready) tick(1);
    check(swOn == 1'b1 && armRest == 1'b1, "R7", {swOn, armRest}, 3);

    // loss of bias reset then restore
    porOk = 1'b0;
    tick(2);
    check({rampStby, swOn, ready} == 3'd0, "R1", {rampStby, swOn, ready}, 0);
    porOk = 1'b1;
    tick(1);
    check(rampStby == 1'b1, "R9", rampStby, 1);

    // random phase checked against the model every cycle
    for (int c = 0; c < 40000; c++) begin
      int r;
      r = $urandom % 1000;
      if (!porOk) porOk = (r < 100);
      else if (r < 2) porOk = 1'b0;
      if (shutdown) shutdown = !(r >= 500 && r < 650);
      else if (r >= 2 && r < 4) shutdown = 1'b1;
      if ($urandom % 100 < 3) mainGood[$urandom % 3] = ~mainGood[$urandom % 3];
      if ($urandom % 100 < 8) mainGood = 3'b111;
      if ($urandom % 200 == 0) slpS3n = ~slpS3n;
      if ($urandom % 200 == 0) slpS5n = ~slpS5n;
      memSelHigh = $urandom % 2;
      cfgEn3 = $urandom % 2;
      cfgEn5 = $urandom % 2;
      tick(1);
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
    $finish;
  end

endmodule